// File: doc/BRIEF.md
# Rise-Time Window Checker

This block watches two level-detector flags for one rising edge of an analog quantity and decides whether the edge was fast enough. One flag reports that the quantity sits above 10 percent of full scale. The other reports that it sits above 90 percent. Each flag is high while the quantity is above its own level and low once the quantity drops back below it.

The first sampled cycle of the run in which the low-level flag is high is the trigger. The trigger can happen only once between resets. From the trigger cycle onward, the high-level flag must be seen within a window of 0 to `WIN_CYC` clock cycles. Seeing it gives a pass verdict. Missing it gives a fail verdict.

The verdict sits in registers and is held until the next reset. Later movement of either flag is ignored. The reset input is asynchronous and active low. Its release is synchronised inside the block, so sampling begins on the third rising clock edge after `rst_n_i` rises.

Top module: `rise_window_chk`

## Requirements
- R1: While reset is active, and right after it, `done_o`, `pass_o` and `fail_o` are all low.
- R2: The trigger is the first active edge at which `lo_flag_i` is high. Until the trigger, all three outputs stay low, whatever `hi_flag_i` does.
- R3: If `hi_flag_i` is high at the trigger edge, `pass_o` and `done_o` go high one cycle later.
- R4: If `hi_flag_i` is first seen at the k-th edge after the trigger, with 1 <= k <= `WIN_CYC`, `pass_o` and `done_o` go high one cycle after that edge.
- R5: If `hi_flag_i` is low at the trigger edge and at each of the `WIN_CYC` edges after it, `fail_o` and `done_o` go high one cycle after the last of those edges.
- R6: If `lo_flag_i` falls after the trigger, the open window is neither cancelled nor restarted.
- R7: Once `done_o` is high, the values of `pass_o` and `fail_o` hold until reset. Later changes of either flag do not re-arm the trigger.
- R8: If `lo_flag_i` is already high when reset is released, the first active edge (the third rising edge after `rst_n_i` rises) is the trigger.
- R9: `done_o` equals `pass_o` OR `fail_o`, and `pass_o` and `fail_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_n_i | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| lo_flag_i | input | 1 | High while the quantity is above 10 percent of full scale |
| hi_flag_i | input | 1 | High while the quantity is above 90 percent of full scale |
| done_o | output | 1 | A verdict has been reached |
| pass_o | output | 1 | The high level was reached inside the window |
| fail_o | output | 1 | The window closed before the high level was reached |

## Verification
An internal fault shows up at the ports as a verdict that arrives in the wrong cycle or carries the wrong polarity.

A window counter that is off by one moves the fail edge, or turns a pass at the `WIN_CYC` boundary into a fail. The scoreboard catches this because it checks the exact cycle in which `done_o` rises.

A trigger latch that re-arms, or a verdict register that does not hold, changes the outputs within a cycle of the later flag activity. The bench drives that activity after every verdict.

A trigger that ignores the first cycle after reset, or that reacts to `hi_flag_i` alone, shifts or creates a verdict on a known cycle. The scoreboard flags that cycle.

// File: rtl/rwc_pkg.sv
`timescale 1ns/1ps
package rwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_PASS = 2'd2,
    ST_FAIL = 2'd3
  } rwc_state_e;

  // Width of a counter that must hold values 0..limit (at least 1 bit).
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/rwc_rst_sync.sv
`timescale 1ns/1ps
module rwc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rwc_first_edge.sv
`timescale 1ns/1ps
module rwc_first_edge (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic lo_flag_i,
  output logic trig_o
);
  logic seen_q;
  logic seen_en;

  // Fires once: the first sampled high of the low-level flag.
  assign trig_o  = lo_flag_i & ~seen_q;
  assign seen_en = trig_o;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      seen_q <= 1'b0;
    end else if (seen_en) begin
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rwc_win_cnt.sv
`timescale 1ns/1ps
module rwc_win_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          start_i,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = start_i | step_i;

  always_comb begin
    if (start_i) begin
      cnt_d = CW'(1);
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rise_window_chk.sv
`timescale 1ns/1ps
module rise_window_chk #(
  parameter int unsigned WIN_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic lo_flag_i,
  input  logic hi_flag_i,
  output logic done_o,
  output logic pass_o,
  output logic fail_o
);
  import rwc_pkg::*;

  localparam int unsigned   CW       = cnt_width(WIN_CYC);
  localparam logic [CW-1:0] LIMIT    = CW'(WIN_CYC);
  localparam bit            ZERO_WIN = (WIN_CYC == 0);

  logic          rst_n_sync;
  logic          trig;
  logic          cnt_start;
  logic          cnt_step;
  logic [CW-1:0] cnt;
  logic          at_limit;
  rwc_state_e    state_q;
  rwc_state_e    state_d;

  rwc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_sync)
  );

  rwc_first_edge u_first_edge (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_sync),
    .lo_flag_i (lo_flag_i),
    .trig_o    (trig)
  );

  rwc_win_cnt #(.CW(CW)) u_win_cnt (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_sync),
    .start_i (cnt_start),
    .step_i  (cnt_step),
    .cnt_o   (cnt)
  );

  assign at_limit = (cnt == LIMIT);

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_start = 1'b0;
    cnt_step  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig) begin
          if (hi_flag_i) begin
            state_d = ST_PASS;
          end else if (ZERO_WIN) begin
            state_d = ST_FAIL;
          end else begin
            state_d   = ST_WAIT;
            cnt_start = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (hi_flag_i) begin
          state_d = ST_PASS;
        end else if (at_limit) begin
          state_d = ST_FAIL;
        end else begin
          cnt_step = 1'b1;
        end
      end
      ST_PASS: state_d = ST_PASS;
      ST_FAIL: state_d = ST_FAIL;
      default: state_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign pass_o = (state_q == ST_PASS);
  assign fail_o = (state_q == ST_FAIL);
  assign done_o = pass_o | fail_o;
endmodule

// File: rtl/rwc_checker.sv
`timescale 1ns/1ps
module rwc_checker (
  input logic clk_i,
  input logic rst_n_i,
  input logic lo_flag_i,
  input logic hi_flag_i,
  input logic done_o,
  input logic pass_o,
  input logic fail_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      seen_q <= 1'b0;
    end else if (lo_flag_i) begin
      seen_q <= 1'b1;
    end
  end

  a_r9_verdict_exclusive: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (done_o == (pass_o || fail_o)) && !(pass_o && fail_o));

  a_r7_verdict_held: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> done_o && $stable(pass_o) && $stable(fail_o));

  a_r2_quiet_before_trigger: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !seen_q |-> !done_o);

  a_r4_hi_in_window_passes: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!done_o && (seen_q || lo_flag_i) && hi_flag_i) |=> pass_o);

  a_r5_fail_without_hi: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(fail_o) |-> !$past(hi_flag_i));
endmodule

bind rise_window_chk rwc_checker u_rwc_checker (
  .clk_i     (clk_i),
  .rst_n_i   (rst_n_sync),
  .lo_flag_i (lo_flag_i),
  .hi_flag_i (hi_flag_i),
  .done_o    (done_o),
  .pass_o    (pass_o),
  .fail_o    (fail_o)
);

// File: tb/test_rise_window_chk.sv
`timescale 1ns/1ps
module test_rise_window_chk;
  localparam int N = 4;

  typedef struct {
    bit    exp_pass;
    int    exp_cyc;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo = 1'b0;
  logic hi = 1'b0;
  logic done_o, pass_o, fail_o;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   reported = 1'b0;
  exp_t sb_q[$];

  rise_window_chk #(.WIN_CYC(N)) i_rise_window_chk (
    .clk_i     (clk),
    .rst_n_i   (rst_n),
    .lo_flag_i (lo),
    .hi_flag_i (hi),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: pop one expected verdict when done rises
  bit done_prev = 1'b0;
  always @(negedge clk) begin
    if (done_o && !done_prev) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected verdict", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(pass_o == e.exp_pass, e.req, "pass_o", int'(pass_o), int'(e.exp_pass));
        chk(fail_o == !e.exp_pass, e.req, "fail_o", int'(fail_o), int'(!e.exp_pass));
        chk(cyc == e.exp_cyc, e.req, "verdict cycle", cyc, e.exp_cyc);
      end
    end
    done_prev = done_o;
  end

  task automatic push(input bit p, input int c, input string req);
    exp_t e;
    e.exp_pass = p;
    e.exp_cyc  = c;
    e.req      = req;
    sb_q.push_back(e);
  endtask

  task automatic do_reset(input bit lo_hold, output int rel_cyc);
    @(negedge clk);
    lo = lo_hold;
    hi = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    chk(!done_o && !pass_o && !fail_o, "R1", "outputs in reset",
        int'({done_o, pass_o, fail_o}), 0);
    rst_n = 1'b1;
    rel_cyc = cyc;
  endtask

  task automatic check_no_verdict(input string req);
    chk(!done_o && !pass_o && !fail_o, req, "outputs before trigger",
        int'({done_o, pass_o, fail_o}), 0);
  endtask

  // Verdict must stay put while both flags toggle (R7)
  task automatic check_held(input bit p);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      lo = k[0];
      hi = k[1];
    end
    @(negedge clk);
    chk(done_o && pass_o == p && fail_o == !p, "R7", "held verdict",
        int'({done_o, pass_o, fail_o}), int'({1'b1, p, !p}));
  endtask

  // One window run: trigger, then hi after d cycles (if hi_ever)
  task automatic run_window(input int d, input bit hi_ever, input bit drop_lo,
                            input string req);
    int rel, c0;
    bit p;
    do_reset(1'b0, rel);
    repeat (4) @(negedge clk);
    check_no_verdict("R1");
    c0 = cyc;
    p = hi_ever && (d <= N);
    push(p, p ? (c0 + 1 + d) : (c0 + 1 + N), req);
    lo = 1'b1;
    if (hi_ever && d == 0) hi = 1'b1;
    for (int k = 1; k <= N + 3; k++) begin
      @(negedge clk);
      if (drop_lo && k == 1) lo = 1'b0;
      if (hi_ever && k == d) hi = 1'b1;
    end
    check_held(p);
  endtask

  initial begin
    int rel;
    // R3: zero-cycle rise
    run_window(0, 1'b1, 1'b0, "R3");
    // R4: inside the window and at its far edge
    run_window(2, 1'b1, 1'b0, "R4");
    run_window(N, 1'b1, 1'b0, "R4");
    // R5: one cycle late, and never
    run_window(N + 1, 1'b1, 1'b0, "R5");
    run_window(0, 1'b0, 1'b0, "R5");
    // R6: low flag drops after the trigger
    run_window(3, 1'b1, 1'b1, "R6");
    run_window(0, 1'b0, 1'b1, "R6");

    // R2: high flag alone must not start anything
    do_reset(1'b0, rel);
    repeat (4) @(negedge clk);
    hi = 1'b1;
    repeat (N + 3) @(negedge clk);
    check_no_verdict("R2");
    hi = 1'b0;
    repeat (2) @(negedge clk);
    check_no_verdict("R2");
    hi = 1'b1;
    push(1'b1, cyc + 1, "R2");
    lo = 1'b1;
    repeat (3) @(negedge clk);
    check_held(1'b1);

    // R8: low flag already high at reset release, no high flag
    do_reset(1'b1, rel);
    push(1'b0, rel + 3 + N, "R8");
    @(negedge clk);
    check_no_verdict("R8");
    repeat (N + 4) @(negedge clk);
    check_held(1'b0);

    // R8: low flag held through reset, high flag arrives two cycles later
    do_reset(1'b1, rel);
    push(1'b1, rel + 5, "R8");
    repeat (4) @(negedge clk);
    hi = 1'b1;
    repeat (3) @(negedge clk);
    check_held(1'b1);

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R9", "pending verdicts", sb_q.size(), 0);
    report();
  end

  initial begin
    #(20 * 20000);
    chk(1'b0, "R1", "watchdog expired", 1, 0);
    report();
  end
endmodule